// File: doc/BRIEF.md
# Step-Attenuator Control Word Interface

This block holds the control word for a six-step digital attenuator and keeps it up to date from one of two external sources. A mode pin chooses between them. In serial mode a three-wire port (data, serial clock, latch enable) shifts bits into a staging register. In parallel mode a six-bit bus drives the word. In either mode the latch enable acts as a transparent latch: while it is high the word follows its source, and while it is low the word holds. Holding latch enable high on the parallel bus gives direct control. Pulsing it gives latched control.

All external pins run at a low rate against a fast system clock. Each pin passes through a synchronizer, and serial clock rising edges are found by edge detection in the system clock domain. The synchronous active-low reset stands in for power-up and loads a starting word that depends on the mode. In serial mode the starting word is a copy of the parallel bus. In parallel mode it comes from a two-bit preset code when latch enable is low, and from the bus when latch enable is high. A one-cycle strobe marks every change of the output word.

Top module: `atten_word_ctrl`

## Requirements
- R1: `ser_mode_i` high selects serial control (the word's source is the shift register); low selects parallel control (the source is `par_word_i`).
- R2: Bit i of `word_o` and of `par_word_i` carries 0.5·2^i dB: bit 0 is 0.5 dB and bit 5 is 16 dB. 000000 is the reference state and 111111 is 31.5 dB.
- R3: In parallel mode with latch enable low, the word holds whatever the bus does. A latch enable pulse captures the bus value present while it is high, and the word keeps that value after the pulse ends.
- R4: In parallel mode with latch enable held high, the word follows every bus change, at most 3 system clock cycles after the change.
- R5: In serial mode each rising edge of `sclk_i` shifts `sdata_i` in, most significant bit first. After six edges the first bit sits at bit 5 (16 dB) and the last at bit 0 (0.5 dB). With more than six edges only the last six bits are kept.
- R6: In serial mode the word follows the shift register while latch enable is high, including through shifts, and holds while latch enable is low.
- R7: Serial mode ignores `par_word_i`. Parallel mode ignores `sclk_i` and `sdata_i`: the shift register does not change.
- R8: Reset in serial mode loads `par_word_i` into the word and clears the shift register to 000000.
- R9: Reset in parallel mode with latch enable low loads the preset, where `preset_i[0]` is the 8 dB select and `preset_i[1]` is the 16 dB select. Code 00 gives 000000, 01 gives 010000, 10 gives 100000 and 11 gives 111110 (31 dB).
- R10: Reset in parallel mode with latch enable high loads `par_word_i`.
- R11: `word_valid_o` is high for exactly the cycles in which `word_o` shows a value different from the previous cycle. It stays low during reset and for the word loaded by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset, used as the power-up event |
| ser_mode_i | input | 1 | Mode select: 1 serial, 0 parallel |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, sampled on its rising edge |
| le_i | input | 1 | Latch enable: high is transparent, low holds |
| par_word_i | input | 6 | Parallel control word, bit 0 = 0.5 dB |
| preset_i | input | 2 | Parallel-mode power-up code |
| word_o | output | 6 | Attenuation control word |
| word_valid_o | output | 1 | One-cycle strobe on each change of `word_o` |

## Verification
The assertions assume that the pins change slowly against the system clock. Serial data is stable around each serial clock rising edge. Every high and low phase of the serial clock and of latch enable spans several system cycles. The bus stays steady while latch enable is high in latched use, and the mode pin changes only while latch enable is low. The bench drives every pin on the falling system clock edge. Each serial clock phase and latch pulse lasts four system cycles. The mode is switched only while latch enable is low. The bus, the preset and the mode are held steady across every reset, so the word loaded at power-up is well defined.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

   // default control word width: six binary-weighted attenuation steps
   localparam int unsigned DEF_WORD_W = 6;

   // parallel-mode power-up preset codes, bit 0 = 8 dB select, bit 1 = 16 dB select
   typedef enum logic [1:0] {
      PRE_REF   = 2'b00,
      PRE_MID   = 2'b01,
      PRE_HIGH  = 2'b10,
      PRE_ALL   = 2'b11
   } preset_code_e;

endpackage

// File: rtl/atten_pin_sync.sv
module atten_pin_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] stg;

   // reset preloads every stage with the live pin value so that no false
   // edge or stale level appears once reset is released
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg <= {STAGES{d_i}};
      end else begin
         stg[0] <= d_i;
         for (int unsigned i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg #(
   parameter int unsigned WORD_W    = 6,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              sclk_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] shreg_o
);

   logic              sclk_q;
   logic              shift_now;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] shreg_nx;

   assign shift_now = enable_i & sclk_i & ~sclk_q;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign shreg_nx = {shreg_q[WORD_W-2:0], sdata_i};

         // R5
         shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            shift_now |=> (shreg_q[WORD_W-1:1] == $past(shreg_q[WORD_W-2:0])));
      end else begin : g_lsb_first
         assign shreg_nx = {sdata_i, shreg_q[WORD_W-1:1]};

         // R5
         shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            shift_now |=> (shreg_q[WORD_W-2:0] == $past(shreg_q[WORD_W-1:1])));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= sclk_i;
         shreg_q <= '0;
      end else begin
         sclk_q <= sclk_i;
         if (shift_now) begin
            shreg_q <= shreg_nx;
         end
      end
   end

   assign shreg_o = shreg_q;

endmodule

// File: rtl/atten_word_reg.sv
module atten_word_reg #(
   parameter int unsigned WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pwr_word_i,
   input  logic              open_i,
   input  logic [WORD_W-1:0] src_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);

   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_d;
   logic              valid_q;

   // transparent latch emulated in the system clock domain
   assign word_d = open_i ? src_i : word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= pwr_word_i;
         valid_q <= 1'b0;
      end else begin
         word_q  <= word_d;
         valid_q <= (word_d != word_q);
      end
   end

   assign word_o  = word_q;
   assign valid_o = valid_q;

   // R11
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (word_q != $past(word_q)));

   // R11
   change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q != $past(word_q)) |-> valid_q);

endmodule

// File: rtl/atten_word_ctrl.sv
module atten_word_ctrl
   import atten_ctrl_pkg::*;
#(
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_mode_i,
   input  logic              sdata_i,
   input  logic              sclk_i,
   input  logic              le_i,
   input  logic [WORD_W-1:0] par_word_i,
   input  logic [1:0]        preset_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o
);

   localparam int unsigned BUS_W   = WORD_W + 4;
   localparam int unsigned MODE_IX = BUS_W - 1;
   localparam int unsigned LE_IX   = BUS_W - 2;
   localparam int unsigned SCLK_IX = BUS_W - 3;
   localparam int unsigned DATA_IX = BUS_W - 4;

   generate
      if (WORD_W < 3) begin : g_bad_width
         $error("atten_word_ctrl: WORD_W must be at least 3");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("atten_word_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0]  pins_raw;
   logic [BUS_W-1:0]  pins_s;
   logic              mode_s;
   logic              le_s;
   logic              sclk_s;
   logic              sdata_s;
   logic [WORD_W-1:0] par_s;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] src;
   logic [WORD_W-1:0] preset_word;
   logic [WORD_W-1:0] pwr_word;

   assign pins_raw = {ser_mode_i, le_i, sclk_i, sdata_i, par_word_i};

   atten_pin_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign mode_s  = pins_s[MODE_IX];
   assign le_s    = pins_s[LE_IX];
   assign sclk_s  = pins_s[SCLK_IX];
   assign sdata_s = pins_s[DATA_IX];
   assign par_s   = pins_s[WORD_W-1:0];

   atten_shift_reg #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (mode_s),
      .sclk_i   (sclk_s),
      .sdata_i  (sdata_s),
      .shreg_o  (shreg)
   );

   // power-up preset, decoded from the raw pins while reset holds them steady
   always_comb begin
      preset_word = '0;
      case (preset_code_e'(preset_i))
         PRE_REF:  preset_word = '0;
         PRE_MID:  preset_word[WORD_W-2] = 1'b1;
         PRE_HIGH: preset_word[WORD_W-1] = 1'b1;
         PRE_ALL:  begin
            preset_word    = '1;
            preset_word[0] = 1'b0;
         end
         default:  preset_word = '0;
      endcase
   end

   assign pwr_word = (ser_mode_i || le_i) ? par_word_i : preset_word;
   assign src      = mode_s ? shreg : par_s;

   atten_word_reg #(
      .WORD_W (WORD_W)
   ) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_word_i (pwr_word),
      .open_i     (le_s),
      .src_i      (src),
      .word_o     (word_o),
      .valid_o    (word_valid_o)
   );

   // R3, R6
   hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !le_s |=> $stable(word_o));

   // R4
   direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_s && le_s) |=> (word_o == $past(par_s)));

   // R6
   serial_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_s && le_s) |=> (word_o == $past(shreg)));

   // R7
   no_shift_parallel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_s |=> $stable(shreg));

endmodule

// File: tb/test_atten_word_ctrl.sv
module test_atten_word_ctrl;

   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_mode = 1'b0;
   logic         sdata = 1'b0;
   logic         sclk = 1'b0;
   logic         le = 1'b0;
   logic [W-1:0] par = '0;
   logic [1:0]   preset = 2'b00;
   logic [W-1:0] word_o;
   logic         word_valid_o;

   always #5 clk = ~clk;

   atten_word_ctrl i_atten_word_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ser_mode_i   (ser_mode),
      .sdata_i      (sdata),
      .sclk_i       (sclk),
      .le_i         (le),
      .par_word_i   (par),
      .preset_i     (preset),
      .word_o       (word_o),
      .word_valid_o (word_valid_o)
   );

   typedef struct {
      logic [W-1:0] w;
      string        tag;
   } exp_t;

   exp_t         exp_q[$];
   int           vectors = 0;
   int           miscompares = 0;
   bit           finished = 1'b0;
   logic [W-1:0] cur_exp = '0;
   logic [W-1:0] shift_exp = '0;

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] expv);
      vectors++;
      if (got !== expv) begin
         miscompares++;
         $display("FAIL %s: got %b expected %b", tag, got, expv);
      end
   endtask

   task automatic check_bit(input string tag, input logic got, input logic expv);
      vectors++;
      if (got !== expv) begin
         miscompares++;
         $display("FAIL %s: got %b expected %b", tag, got, expv);
      end
   endtask

   // driver side of the scoreboard: queue an update only when the word changes
   task automatic expect_word(input string tag, input logic [W-1:0] w);
      exp_t e;
      if (w != cur_exp) begin
         e.w   = w;
         e.tag = tag;
         exp_q.push_back(e);
         cur_exp = w;
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && word_valid_o) begin
         vectors++;
         if (exp_q.size() == 0) begin
            miscompares++;
            $display("FAIL R11: unexpected update got %b expected no change", word_o);
         end else begin
            e = exp_q.pop_front();
            if (word_o !== e.w) begin
               miscompares++;
               $display("FAIL %s: got %b expected %b", e.tag, word_o, e.w);
            end
         end
      end
   end

   task automatic drain(input string tag);
      cyc(10);
      vectors++;
      if (exp_q.size() != 0) begin
         miscompares++;
         $display("FAIL %s: got %0d pending updates expected 0", tag, exp_q.size());
      end
      exp_q.delete();
      check(tag, word_o, cur_exp);
   endtask

   task automatic do_reset(input logic m, input logic l, input logic [1:0] pr,
                           input logic [W-1:0] pw, input logic [W-1:0] expw, input string tag);
      drain(tag);
      ser_mode = m;
      le       = l;
      preset   = pr;
      par      = pw;
      sclk     = 1'b0;
      rst_n    = 1'b0;
      cyc(4);
      check_bit("R11 strobe in reset", word_valid_o, 1'b0);
      rst_n = 1'b1;
      cyc(1);
      check(tag, word_o, expw);
      check_bit("R11 strobe after reset", word_valid_o, 1'b0);
      cur_exp   = expw;
      shift_exp = '0;
      exp_q.delete();
   endtask

   task automatic set_le(input logic v, input string tag);
      le = v;
      if (v) expect_word(tag, ser_mode ? shift_exp : par);
   endtask

   task automatic set_par(input logic [W-1:0] v, input string tag);
      par = v;
      if (!ser_mode && le) expect_word(tag, v);
   endtask

   task automatic sbit(input logic b, input string tag);
      sdata = b;
      cyc(4);
      sclk = 1'b1;
      if (ser_mode) begin
         shift_exp = {shift_exp[W-2:0], b};
         if (le) expect_word(tag, shift_exp);
      end
      cyc(4);
      sclk = 1'b0;
   endtask

   task automatic shift_word(input logic [W-1:0] w, input string tag);
      for (int i = W - 1; i >= 0; i--) sbit(w[i], tag);
      cyc(4);
   endtask

   task automatic pulse_le(input string tag);
      set_le(1'b1, tag);
      cyc(4);
      le = 1'b0;
      cyc(4);
   endtask

   initial begin
      cyc(3);
      // R9: every preset code, parallel mode, latch enable low
      do_reset(1'b0, 1'b0, 2'b00, 6'b101010, 6'b000000, "R9 preset 00");
      do_reset(1'b0, 1'b0, 2'b01, 6'b101010, 6'b010000, "R9 preset 01 8dB");
      do_reset(1'b0, 1'b0, 2'b10, 6'b101010, 6'b100000, "R9 preset 10 16dB");
      do_reset(1'b0, 1'b0, 2'b11, 6'b101010, 6'b111110, "R9 R2 preset 11 31dB");

      // R10: parallel power-up with latch enable high copies the bus
      do_reset(1'b0, 1'b1, 2'b11, 6'b010101, 6'b010101, "R10 powerup from bus");

      // R4: direct parallel mode follows the bus
      set_par(6'b111111, "R4 direct 31.5dB");
      cyc(6);
      check("R4 direct settle", word_o, 6'b111111);
      set_par(6'b000001, "R4 R2 direct 0.5dB");
      cyc(6);
      set_par(6'b100000, "R4 direct 16dB");
      cyc(1);
      set_par(6'b011011, "R4 back-to-back");
      drain("R4 direct");

      // R3: latched parallel mode
      le = 1'b0;
      cyc(4);
      set_par(6'b110011, "R3 bus moves while closed");
      cyc(6);
      set_par(6'b001100, "R3 bus moves while closed");
      drain("R3 hold while low");
      check("R3 held word", word_o, 6'b011011);
      pulse_le("R3 capture on pulse");
      set_par(6'b111000, "R3 change after pulse");
      drain("R3 after pulse");
      check("R3 captured word", word_o, 6'b001100);

      // R7: serial clock ignored in parallel mode
      for (int k = 0; k < 8; k++) sbit(1'b1, "R7 sclk in parallel mode");
      drain("R7 parallel ignores sclk");

      // R1: switch to serial mode while closed, open: source is the shift register
      ser_mode = 1'b1;
      cyc(6);
      drain("R1 mode switch while closed");
      pulse_le("R1 R7 serial source untouched");
      drain("R1 serial source");
      check("R7 shift register stayed clear", word_o, 6'b000000);

      // R5, R6: shift with latch closed, then open
      shift_word(6'b101101, "R5 shift");
      drain("R6 hold during shift");
      check("R6 word held while shifting", word_o, 6'b000000);
      pulse_le("R5 MSB first word");
      drain("R5 MSB first");
      check("R5 R2 serial word", word_o, 6'b101101);
      shift_word(6'b010011, "R5 second word");
      check("R6 closed hold", word_o, 6'b101101);
      pulse_le("R5 second word");
      drain("R5 second word");

      // R6: transparent while open, every shift passes through
      set_le(1'b1, "R6 open");
      cyc(6);
      shift_word(6'b110001, "R6 transparent shift");
      drain("R6 transparent");
      check("R6 transparent result", word_o, 6'b110001);

      // R7: bus ignored in serial mode while open
      set_par(6'b000111, "R7 bus in serial mode");
      cyc(6);
      set_par(6'b111000, "R7 bus in serial mode");
      drain("R7 serial ignores bus");
      check("R7 serial ignores bus", word_o, 6'b110001);
      le = 1'b0;
      cyc(6);

      // R5: more than six bits keeps only the last six
      for (int k = 0; k < 2; k++) sbit(1'b1, "R5 overlong");
      shift_word(6'b000110, "R5 overlong");
      pulse_le("R5 last six bits");
      drain("R5 overlong");
      check("R5 overlong result", word_o, 6'b000110);

      // R8: serial power-up copies the bus and clears the shift register
      do_reset(1'b1, 1'b0, 2'b11, 6'b110011, 6'b110011, "R8 serial powerup");
      pulse_le("R8 shift register cleared");
      drain("R8 cleared");
      check("R8 cleared shift register", word_o, 6'b000000);

      drain("final");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule